// File: doc/BRIEF.md
# I2C Master Repeated-Start Sequencer

This block places an I2C Repeated Start on a pair of open-drain lines when software asks for one. Software sets a request bit in a five-bit control field. If neither this block nor any other bus event is active, the sequencer takes over the lines and runs four phases:

1. It pulls SCL low.
2. It lets SDA float high for one baud period.
3. It lets SCL float high, waits until SCL is actually seen high, and holds both lines high for one baud period.
4. It pulls SDA low for one more baud period while SCL stays high.

It then clears the request bit, raises a completion flag and leaves SDA held low. The byte logic that follows uses the bus from there.

The length of each phase comes from a 7-bit reload value that a down-counter loads at the start of a phase. Every decision is taken on pin levels that have passed through a two-flop synchronizer. A slave that stretches SCL therefore simply extends the release phase. While the sequence runs, the block watches for another master. It also refuses writes to the transmit byte register and to the control field.

Top module: `i2c_rs_seq`

## Requirements
- R1: A request, written as control bit 1 set, is accepted only when the sequencer is idle and `other_busy` is low. When `other_busy` is high, the request bit stays 0 and SCL is not driven.
- R2: On acceptance, SCL is driven low. SDA is released only after SCL has been seen low through the synchronizer. The SDA-release phase then lasts N clocks, where N is `brg_reload` and N is not zero.
- R3: SCL is released only when the SDA-release phase has ended and SDA is seen high. The both-high phase of N clocks starts only once SCL is seen high. Each clock of slave stretching delays completion by one clock.
- R4: SDA is driven low for N clocks while SCL stays released. After that, control bit 1 clears, `rs_irq` sets, SDA stays held low and SCL stays released. Without stretching, the completion edge is the (3N+6)-th rising edge after the edge that accepted the request.
- R5: `start_det` sets whenever the synchronized SDA falls while the synchronized SCL is high.
- R6: If SDA is seen low at the moment the released SCL is first seen high, `bus_coll` sets. The sequence then aborts with both lines released, control bit 1 cleared and no `rs_irq`.
- R7: If SCL is seen low during the both-high phase, before SDA has been driven, `bus_coll` sets and the sequence aborts in the same way as in R6.
- R8: A transmit-buffer write sampled while the sequence runs sets `wr_coll` and leaves `txb_q` unchanged. This includes the completion edge itself. A write sampled while idle loads `txb_q`.
- R9: Control writes sampled while the sequence runs leave all five control bits unchanged, so no event can be queued.
- R10: Reset clears the control field, `txb_q` and all four flags, and releases both lines. `flags_clr` clears `rs_irq`, `bus_coll`, `wr_coll` and `start_det`, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| brg_reload | input | 7 | Baud period length N in clocks, nonzero |
| ctl_wr | input | 1 | Control field write strobe |
| ctl_wdata | input | 5 | Control write data, bit 1 is the repeated-start request |
| other_busy | input | 1 | Another bus event is in progress |
| txb_wr | input | 1 | Transmit buffer write strobe |
| txb_wdata | input | 8 | Transmit buffer write data |
| flags_clr | input | 1 | Clears the four status flags |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| ctl_q | output | 5 | Control field |
| txb_q | output | 8 | Transmit buffer contents |
| start_det | output | 1 | Start pattern seen on the pins |
| rs_irq | output | 1 | Repeated start completed |
| bus_coll | output | 1 | Bus collision during the sequence |
| wr_coll | output | 1 | Transmit buffer written while busy |

## Verification
The completion of the sequence and a software write to the transmit buffer can land on the same clock edge. That edge clears the request bit and raises `rs_irq`, and the write must still be treated as arriving during the sequence. The bench counts clocks from the accepting edge to the computed completion edge (3N+6) and drives the buffer write so that it is sampled exactly there. It then expects `rs_irq` and `wr_coll` both set with `txb_q` unchanged, and it expects a write one clock later to load the buffer.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCL_DN,
    ST_SDA_UP,
    ST_SCL_UP,
    ST_BOTH_HI,
    ST_SDA_DN
  } rs_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = stg_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '1;
      else        stg_q[g] <= src;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_brg.sv
module i2c_rs_brg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic         period_end
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = reload;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Period ends on the edge where the count leaves 1; stays ended at 0.
  assign period_end = (cnt_q <= W'(1));
endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
  import i2c_rs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic scl_s,
  input  logic sda_s,
  input  logic period_end,
  output logic load,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done,
  output logic coll
);
  rs_state_e state_q, state_d;
  logic      hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    hold_d  = hold_q;
    load    = 1'b0;
    done    = 1'b0;
    coll    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_ok) state_d = ST_SCL_DN;
      ST_SCL_DN: if (!scl_s) begin
        state_d = ST_SDA_UP;
        load    = 1'b1;
        hold_d  = 1'b0;
      end
      ST_SDA_UP: if (period_end && sda_s) state_d = ST_SCL_UP;
      ST_SCL_UP: if (scl_s) begin
        if (!sda_s) begin
          coll    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_BOTH_HI;
          load    = 1'b1;
        end
      end
      ST_BOTH_HI: begin
        if (!scl_s) begin
          coll    = 1'b1;
          state_d = ST_IDLE;
        end else if (period_end) begin
          state_d = ST_SDA_DN;
          load    = 1'b1;
        end
      end
      ST_SDA_DN: if (period_end) begin
        done    = 1'b1;
        hold_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      hold_q  <= hold_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign scl_oe = (state_q == ST_SCL_DN) || (state_q == ST_SDA_UP);
  assign sda_oe = (state_q == ST_SDA_DN) ||
                  (hold_q && ((state_q == ST_IDLE) || (state_q == ST_SCL_DN)));

  // SDA may only be let go while SCL is being pulled low.
  assert_sda_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> scl_oe);

  // SCL is let go only with SDA already released.
  assert_scl_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> !sda_oe);

  // A collision (R6, R7) leaves both lines released and the machine idle.
  assert_abort_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (!scl_oe && !sda_oe && !busy));
endmodule

// File: rtl/i2c_rs_seq.sv
module i2c_rs_seq #(
  parameter int BRG_W  = 7,
  parameter int CTL_W  = 5,
  parameter int RS_BIT = 1,
  parameter int TXB_W  = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRG_W-1:0] brg_reload,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             other_busy,
  input  logic             txb_wr,
  input  logic [TXB_W-1:0] txb_wdata,
  input  logic             flags_clr,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [CTL_W-1:0] ctl_q,
  output logic [TXB_W-1:0] txb_q,
  output logic             start_det,
  output logic             rs_irq,
  output logic             bus_coll,
  output logic             wr_coll
);
  localparam logic [CTL_W-1:0] RS_MASK = CTL_W'(1) << RS_BIT;

  logic       scl_s, sda_s, sda_d;
  logic [1:0] pins_s;
  logic       load, period_end, busy, done, coll, start_ok, start_pat;

  logic [CTL_W-1:0] ctl_d;
  logic [TXB_W-1:0] txb_d;
  logic             sdet_d, irq_d, bcol_d, wcol_d;

  i2c_rs_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk (clk), .rst_n (rst_n), .d ({scl_in, sda_in}), .q (pins_s)
  );
  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  i2c_rs_brg #(.W(BRG_W)) u_brg (
    .clk (clk), .rst_n (rst_n), .load (load), .reload (brg_reload),
    .period_end (period_end)
  );

  assign start_ok = ctl_wr && !busy && !other_busy && ctl_wdata[RS_BIT];

  i2c_rs_fsm u_fsm (
    .clk (clk), .rst_n (rst_n), .start_ok (start_ok), .scl_s (scl_s),
    .sda_s (sda_s), .period_end (period_end), .load (load),
    .scl_oe (scl_oe), .sda_oe (sda_oe), .busy (busy), .done (done),
    .coll (coll)
  );

  assign start_pat = scl_s && sda_d && !sda_s;

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr && !busy) begin
      ctl_d = ctl_wdata;
      if (other_busy) ctl_d = ctl_wdata & ~RS_MASK;
    end
    if (done || coll) ctl_d = ctl_d & ~RS_MASK;

    txb_d = txb_q;
    if (txb_wr && !busy) txb_d = txb_wdata;

    sdet_d = flags_clr ? 1'b0 : start_det;
    irq_d  = flags_clr ? 1'b0 : rs_irq;
    bcol_d = flags_clr ? 1'b0 : bus_coll;
    wcol_d = flags_clr ? 1'b0 : wr_coll;
    if (start_pat)      sdet_d = 1'b1;
    if (done)           irq_d  = 1'b1;
    if (coll)           bcol_d = 1'b1;
    if (txb_wr && busy) wcol_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      txb_q     <= '0;
      sda_d     <= 1'b1;
      start_det <= 1'b0;
      rs_irq    <= 1'b0;
      bus_coll  <= 1'b0;
      wr_coll   <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      txb_q     <= txb_d;
      sda_d     <= sda_s;
      start_det <= sdet_d;
      rs_irq    <= irq_d;
      bus_coll  <= bcol_d;
      wr_coll   <= wcol_d;
    end
  end

  assert_busy_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && other_busy && !busy) |=> (!ctl_q[RS_BIT] && !scl_oe));

  assert_req_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[RS_BIT]) |-> (rs_irq || bus_coll));

  assert_txb_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (txb_wr && busy) |=> (wr_coll && $stable(txb_q)));

  assert_ctl_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && busy) |=> ((ctl_q & ~RS_MASK) == ($past(ctl_q) & ~RS_MASK)));
endmodule

// File: tb/sim_i2c_rs_seq.sv
module sim_i2c_rs_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] brg_reload;
  logic       ctl_wr, other_busy, txb_wr, flags_clr;
  logic [4:0] ctl_wdata;
  logic [7:0] txb_wdata;
  logic       ext_scl_low, ext_sda_low;
  logic       scl_in, sda_in, scl_oe, sda_oe;
  logic [4:0] ctl_q;
  logic [7:0] txb_q;
  logic       start_det, rs_irq, bus_coll, wr_coll;

  int n_chk = 0;
  int n_err = 0;

  // N, stretch clocks, negedge count at which rs_irq is first seen (3N+7+S)
  localparam logic [23:0] VEC [5] = '{
    24'h03_00_10, 24'h04_02_15, 24'h07_00_1C, 24'h0A_05_2A, 24'h05_01_17
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_in = ~(scl_oe | ext_scl_low);
  assign sda_in = ~(sda_oe | ext_sda_low);

  i2c_rs_seq u0 (
    .clk (clk), .rst_n (rst_n), .brg_reload (brg_reload), .ctl_wr (ctl_wr),
    .ctl_wdata (ctl_wdata), .other_busy (other_busy), .txb_wr (txb_wr),
    .txb_wdata (txb_wdata), .flags_clr (flags_clr), .scl_in (scl_in),
    .sda_in (sda_in), .scl_oe (scl_oe), .sda_oe (sda_oe), .ctl_q (ctl_q),
    .txb_q (txb_q), .start_det (start_det), .rs_irq (rs_irq),
    .bus_coll (bus_coll), .wr_coll (wr_coll)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic clear_flags();
    @(negedge clk); flags_clr = 1'b1;
    @(negedge clk); flags_clr = 1'b0;
  endtask

  // Issue a request; return the negedge count at which rs_irq shows.
  task automatic run_seq(input int n, input int s, output int cnt);
    int rem = 0;
    logic prev;
    brg_reload = 7'(n);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 5'b00010;
    prev = scl_oe;
    cnt = -1;
    for (int k = 1; k < 300; k++) begin
      @(negedge clk);
      if (k == 1) ctl_wr = 1'b0;
      if (rem > 0) begin
        rem--;
        if (rem == 0) ext_scl_low = 1'b0;
      end
      if (prev && !scl_oe && s > 0) begin
        ext_scl_low = 1'b1;
        rem = s;
      end
      prev = scl_oe;
      if (rs_irq || bus_coll) begin
        cnt = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    int cnt;
    rst_n = 1'b0; brg_reload = 7'd4; ctl_wr = 1'b0; ctl_wdata = '0;
    other_busy = 1'b0; txb_wr = 1'b0; txb_wdata = '0; flags_clr = 1'b0;
    ext_scl_low = 1'b0; ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 scl_oe", scl_oe, 0);
    chk("R10 sda_oe", sda_oe, 0);
    chk("R10 ctl_q", ctl_q, 0);
    chk("R10 flags", {start_det, rs_irq, bus_coll, wr_coll}, 0);

    // R1 request ignored while another event is busy
    other_busy = 1'b1; ctl_wr = 1'b1; ctl_wdata = 5'b00010;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 request bit", ctl_q[1], 0);
    chk("R1 scl_oe", scl_oe, 0);
    other_busy = 1'b0;

    // Table walk: R2, R3, R4, R5
    foreach (VEC[i]) begin
      run_seq(int'(VEC[i][23:16]), int'(VEC[i][15:8]), cnt);
      chk("R4 completion clock", cnt, int'(VEC[i][7:0]));
      chk("R4 request cleared", ctl_q[1], 0);
      chk("R4 sda held low", sda_oe, 1);
      chk("R3 scl released", scl_oe, 0);
      chk("R5 start seen", start_det, 1);
      chk("R6 no collision", bus_coll, 0);
      clear_flags();
    end
    chk("R10 flags cleared", {start_det, rs_irq, bus_coll, wr_coll}, 0);

    // R9 / R8 writes during a running sequence
    brg_reload = 7'd6;
    @(negedge clk); txb_wr = 1'b1; txb_wdata = 8'h5A;
    @(negedge clk); txb_wr = 1'b0;
    chk("R8 idle write loads", txb_q, 8'h5A);
    chk("R8 idle write no flag", wr_coll, 0);
    ctl_wr = 1'b1; ctl_wdata = 5'b00010;
    @(negedge clk); ctl_wr = 1'b0;
    repeat (3) @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 5'b11101;
    @(negedge clk); ctl_wr = 1'b0;
    chk("R9 control unchanged", ctl_q, 5'b00010);
    txb_wr = 1'b1; txb_wdata = 8'hC3;
    @(negedge clk); txb_wr = 1'b0;
    chk("R8 busy write flag", wr_coll, 1);
    chk("R8 busy write no load", txb_q, 8'h5A);
    repeat (40) @(negedge clk);
    chk("R4 irq after blocked writes", rs_irq, 1);
    clear_flags();

    // R8 write on the completion edge (N=4: edge 18 after acceptance)
    brg_reload = 7'd4;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 5'b00010;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      txb_wr = 1'b0;
      if (k == 1)  ctl_wr = 1'b0;
      if (k == 17) chk("R4 irq not early", rs_irq, 0);
      if (k == 19) begin
        chk("R4 irq on completion", rs_irq, 1);
        chk("R8 same-edge flag", wr_coll, 1);
        chk("R8 same-edge no load", txb_q, 8'h5A);
      end
      if (k == 20) chk("R8 next write loads", txb_q, 8'h77);
      if (k == 18) begin txb_wr = 1'b1; txb_wdata = 8'hE1; end
      if (k == 19) begin txb_wr = 1'b1; txb_wdata = 8'h77; end
    end
    clear_flags();

    // R6 SDA held low by another device when SCL comes up
    brg_reload = 7'd5;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 5'b00010;
    @(negedge clk); ctl_wr = 1'b0;
    while (scl_oe || ctl_q[1] == 1'b0) @(negedge clk);
    while (scl_oe) @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 collision flag", bus_coll, 1);
    chk("R6 request cleared", ctl_q[1], 0);
    chk("R6 lines released", {scl_oe, sda_oe}, 0);
    chk("R6 no irq", rs_irq, 0);
    ext_sda_low = 1'b0;
    repeat (4) @(negedge clk);
    clear_flags();

    // R7 SCL pulled low during the both-high phase
    brg_reload = 7'd10;
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 5'b00010;
    @(negedge clk); ctl_wr = 1'b0;
    while (!scl_oe) @(negedge clk);
    while (scl_oe) @(negedge clk);
    repeat (6) @(negedge clk);
    ext_scl_low = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 collision flag", bus_coll, 1);
    chk("R7 sda never driven", sda_oe, 0);
    chk("R7 request cleared", ctl_q[1], 0);
    chk("R7 no irq", rs_irq, 0);
    ext_scl_low = 1'b0;
    repeat (4) @(negedge clk);

    // R5 start pattern made by another device; R10 clear
    clear_flags();
    ext_sda_low = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5 external start", start_det, 1);
    ext_sda_low = 1'b0;
    repeat (4) @(negedge clk);
    clear_flags();
    chk("R10 clear all", {start_det, rs_irq, bus_coll, wr_coll}, 0);

    report();
  end
endmodule